// File: doc/BRIEF.md
# 128-bit Lane Interleave and Copy Unit

This block forms a 128-bit result from two 128-bit source operands by rearranging their lanes. It does no arithmetic. It supports three kinds of operation:

- interleaving the lower 64-bit halves of both sources at byte, halfword or word granularity;
- interleaving the upper halves at word granularity;
- combining whole 64-bit halves of the two sources, or broadcasting one halfword across each half.

It sits in the writeback path of a register-file datapath. The caller supplies the two operand values, the register indices they were read from, an opcode and a destination index. Each source is treated as zero when its index is zero. The permutation is pure wiring selected by the opcode. The result, the write enable and the destination index are registered once, so they appear on the cycle after the request. A destination index of zero suppresses the write. An opcode outside the supported set raises an illegal flag for one cycle and also suppresses the write.

Top module: `lane_permute_unit`

## Requirements
- R1: Opcode 0 (byte interleave): result byte 2k is rt byte k and result byte 2k+1 is rs byte k, for k = 0..7 taken from bits 63:0 of each source.
- R2: Opcode 1 (halfword interleave): result halfword 2k is rt halfword k and result halfword 2k+1 is rs halfword k, for k = 0..3 from bits 63:0.
- R3: Opcode 2 (word interleave, lower): result word 2k is rt word k and result word 2k+1 is rs word k, for k = 0..1 from bits 63:0.
- R4: Opcode 3 (word interleave, upper): the same rt-low, rs-high word pairing as R3, taken from bits 127:64 of both sources.
- R5: Opcode 4 (halfword broadcast): rt bits 15:0 fill all four halfwords of result bits 63:0, and rt bits 79:64 fill all four halfwords of result bits 127:64.
- R6: Opcode 5 (copy lower doublewords): result bits 63:0 are rt bits 63:0 and result bits 127:64 are rs bits 63:0.
- R7: Opcode 6 (copy upper doublewords): result bits 63:0 are rs bits 127:64 and result bits 127:64 are rt bits 127:64.
- R8: A source whose index is zero is used as all zeros, whatever its data input carries.
- R9: A valid, legal request with destination index zero gives we_o low on the next cycle and leaves res_o and rd_o unchanged.
- R10: A valid request with an opcode of 7 to 15 gives illegal_o high and we_o low on the next cycle, and leaves res_o and rd_o unchanged.
- R11: A valid, legal request with a nonzero destination gives we_o high, res_o equal to the permutation and rd_o equal to the destination, exactly one cycle later. A cycle with valid_i low gives we_o and illegal_o low on the next cycle, and res_o and rd_o hold their values.
- R12: While reset is asserted, res_o, we_o, rd_o and illegal_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Permutation opcode |
| rs_idx_i | input | 5 | Register index of the rs operand |
| rt_idx_i | input | 5 | Register index of the rt operand |
| rd_idx_i | input | 5 | Destination register index |
| rs_data_i | input | 128 | rs operand value |
| rt_data_i | input | 128 | rt operand value |
| res_o | output | 128 | Registered result |
| we_o | output | 1 | Result write enable |
| rd_o | output | 5 | Destination index of the result |
| illegal_o | output | 1 | Unsupported opcode was requested |

## Verification
The assertions assume that the request inputs are stable around the rising edge and free of X whenever valid_i is high. They also assume that op_i carries meaning only while valid_i is high. The stimulus changes inputs only on the falling edge. It gives every byte of each source a different value that encodes its position, so any misplaced element shows up as a wrong byte. The stimulus reaches the zero-index, zero-destination, idle and illegal-opcode cases both on their own and mixed into a long stream of back-to-back requests.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

  typedef enum logic [3:0] {
    OP_ILV_B   = 4'd0,
    OP_ILV_H   = 4'd1,
    OP_ILV_W   = 4'd2,
    OP_ILV_UW  = 4'd3,
    OP_BCAST_H = 4'd4,
    OP_CPY_LO  = 4'd5,
    OP_CPY_HI  = 4'd6
  } perm_op_e;

  localparam int NUM_LO_ILV = 3;
  localparam int BASE_ELEM_W = 8;

endpackage

// File: rtl/lane_interleave.sv
module lane_interleave #(
  parameter int HALF_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [HALF_W-1:0]   lo_src_i,
  input  logic [HALF_W-1:0]   hi_src_i,
  output logic [2*HALF_W-1:0] y_o
);
  localparam int N_ELEM = HALF_W / ELEM_W;

  for (genvar k = 0; k < N_ELEM; k++) begin : g_pair
    assign y_o[2*k*ELEM_W     +: ELEM_W] = lo_src_i[k*ELEM_W +: ELEM_W];
    assign y_o[(2*k+1)*ELEM_W +: ELEM_W] = hi_src_i[k*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/lane_bcast.sv
module lane_bcast #(
  parameter int HALF_W = 64,
  parameter int ELEM_W = 16
) (
  input  logic [ELEM_W-1:0]   lo_elem_i,
  input  logic [ELEM_W-1:0]   hi_elem_i,
  output logic [2*HALF_W-1:0] y_o
);
  localparam int N_ELEM = HALF_W / ELEM_W;

  assign y_o = {{N_ELEM{hi_elem_i}}, {N_ELEM{lo_elem_i}}};
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lane_perm_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5,
  parameter int OP_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  rs_idx_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [DATA_W-1:0] rt_data_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic              illegal_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HWORD_W = 16;
  localparam int WORD_W  = 32;

  logic [DATA_W-1:0] rs_v, rt_v;
  assign rs_v = (rs_idx_i == '0) ? '0 : rs_data_i;
  assign rt_v = (rt_idx_i == '0) ? '0 : rt_data_i;

  // lower-half interleaves at 8/16/32-bit elements
  logic [NUM_LO_ILV-1:0][DATA_W-1:0] ilv_lo;
  for (genvar g = 0; g < NUM_LO_ILV; g++) begin : g_ilv_lo
    lane_interleave #(.HALF_W(HALF_W), .ELEM_W(BASE_ELEM_W << g)) u_ilv (
      .lo_src_i (rt_v[HALF_W-1:0]),
      .hi_src_i (rs_v[HALF_W-1:0]),
      .y_o      (ilv_lo[g])
    );
  end

  logic [DATA_W-1:0] ilv_hi_w;
  lane_interleave #(.HALF_W(HALF_W), .ELEM_W(WORD_W)) u_ilv_hi (
    .lo_src_i (rt_v[DATA_W-1:HALF_W]),
    .hi_src_i (rs_v[DATA_W-1:HALF_W]),
    .y_o      (ilv_hi_w)
  );

  logic [DATA_W-1:0] bcast_h;
  lane_bcast #(.HALF_W(HALF_W), .ELEM_W(HWORD_W)) u_bcast (
    .lo_elem_i (rt_v[HWORD_W-1:0]),
    .hi_elem_i (rt_v[HALF_W+HWORD_W-1:HALF_W]),
    .y_o       (bcast_h)
  );

  logic [DATA_W-1:0] perm;
  logic              op_legal;
  always_comb begin
    op_legal = 1'b1;
    perm     = '0;
    case (perm_op_e'(op_i))
      OP_ILV_B:   perm = ilv_lo[0];
      OP_ILV_H:   perm = ilv_lo[1];
      OP_ILV_W:   perm = ilv_lo[2];
      OP_ILV_UW:  perm = ilv_hi_w;
      OP_BCAST_H: perm = bcast_h;
      OP_CPY_LO:  perm = {rs_v[HALF_W-1:0], rt_v[HALF_W-1:0]};
      OP_CPY_HI:  perm = {rt_v[DATA_W-1:HALF_W], rs_v[DATA_W-1:HALF_W]};
      default:    op_legal = 1'b0;
    endcase
  end

  logic do_write;
  assign do_write = valid_i && op_legal && (rd_idx_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      we_o      <= 1'b0;
      rd_o      <= '0;
      illegal_o <= 1'b0;
    end else begin
      we_o      <= do_write;
      illegal_o <= valid_i && !op_legal;
      if (do_write) begin
        res_o <= perm;
        rd_o  <= rd_idx_i;
      end
    end
  end

  // R10
  we_illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && illegal_o));

  // R9
  rd_zero_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (rd_o != '0));

  // R11
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> ($stable(res_o) && $stable(rd_o)));

  // R11
  legal_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_legal && rd_idx_i != '0) |=> we_o);

  // R10
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_legal) |=> (illegal_o && !we_o));

  // R5
  bcast_repl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(op_i) == OP_BCAST_H) |->
      (res_o[2*HWORD_W-1:HWORD_W] == res_o[HWORD_W-1:0] &&
       res_o[DATA_W-1:DATA_W-HWORD_W] == res_o[HALF_W+HWORD_W-1:HALF_W]));

  // R6
  cpy_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(op_i) == OP_CPY_LO) |->
      (res_o[HALF_W-1:0] == $past(rt_v[HALF_W-1:0])));

endmodule

// File: tb/tb_lane_permute_unit.sv
module tb_lane_permute_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [4:0]   rs_idx_i = '0, rt_idx_i = '0, rd_idx_i = '0;
  logic [127:0] rs_data_i = '0, rt_data_i = '0;
  logic [127:0] res_o;
  logic         we_o, illegal_o;
  logic [4:0]   rd_o;

  int checks = 0;
  int fails  = 0;

  logic [127:0] exp_res = '0;
  logic         exp_we = 1'b0, exp_ill = 1'b0;
  logic [4:0]   exp_rd = '0;
  string        exp_tag = "R12";

  always #10 clk_i = ~clk_i;

  lane_permute_unit dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .rs_idx_i, .rt_idx_i, .rd_idx_i,
    .rs_data_i, .rt_data_i, .res_o, .we_o, .rd_o, .illegal_o
  );

  function automatic logic [127:0] ref_perm(int op, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int w, off;
    case (op)
      0, 1, 2, 3: begin
        w   = (op == 3) ? 32 : (8 << op);
        off = (op == 3) ? 64 : 0;
        for (int j = 0; j < 128; j++) begin
          int k = j / w;
          int src = off + (k / 2) * w + (j % w);
          r[j] = (k % 2 == 0) ? b[src] : a[src];
        end
      end
      4: for (int j = 0; j < 128; j++) r[j] = b[(j / 64) * 64 + (j % 16)];
      5: r = {a[63:0], b[63:0]};
      6: r = {b[127:64], a[127:64]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] pattern(logic [3:0] tag, int seed);
    logic [127:0] p;
    for (int n = 0; n < 16; n++) p[n*8 +: 8] = {tag, n[3:0]} ^ seed[7:0];
    return p;
  endfunction

  task automatic check();
    checks++;
    if (we_o !== exp_we || illegal_o !== exp_ill || rd_o !== exp_rd || res_o !== exp_res) begin
      fails++;
      $display("FAIL %s: we=%b ill=%b rd=%0d res=%h, expected we=%b ill=%b rd=%0d res=%h",
               exp_tag, we_o, illegal_o, rd_o, res_o, exp_we, exp_ill, exp_rd, exp_res);
    end
  endtask

  task automatic step(input logic v, input int op, input int rd, input int rsi, input int rti,
                      input logic [127:0] rsd, input logic [127:0] rtd);
    logic [127:0] a, b;
    logic legal;
    @(negedge clk_i);
    check();
    valid_i = v; op_i = op[3:0]; rd_idx_i = rd[4:0];
    rs_idx_i = rsi[4:0]; rt_idx_i = rti[4:0]; rs_data_i = rsd; rt_data_i = rtd;
    a = (rsi == 0) ? '0 : rsd;
    b = (rti == 0) ? '0 : rtd;
    legal = (op <= 6);
    exp_we  = v && legal && rd != 0;
    exp_ill = v && !legal;
    if (exp_we) begin
      exp_res = ref_perm(op, a, b);
      exp_rd  = rd[4:0];
    end
    if (!v) exp_tag = "R11";
    else if (!legal) exp_tag = "R10";
    else if (rd == 0) exp_tag = "R9";
    else if (rsi == 0 || rti == 0) exp_tag = "R8";
    else begin
      case (op)
        0: exp_tag = "R1"; 1: exp_tag = "R2"; 2: exp_tag = "R3"; 3: exp_tag = "R4";
        4: exp_tag = "R5"; 5: exp_tag = "R6"; default: exp_tag = "R7";
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (2) begin @(negedge clk_i); check(); end
    rst_ni = 1'b1;
    // R1..R7 each opcode, distinct position-encoded bytes
    for (int op = 0; op < 7; op++)
      step(1, op, op + 1, 3, 4, pattern(4'hA, op), pattern(4'h5, op * 3));
    // R8 zero source index
    for (int op = 0; op < 7; op++) begin
      step(1, op, 7, 0, 9, pattern(4'hC, 1), pattern(4'h3, 2));
      step(1, op, 8, 9, 0, pattern(4'hC, 5), pattern(4'h3, 6));
    end
    // R9 destination zero, R10 illegal, R11 idle cycles
    step(1, 2, 0, 1, 2, pattern(4'h9, 0), pattern(4'h6, 0));
    for (int op = 7; op < 16; op++)
      step(1, op, 5, 1, 2, pattern(4'h7, op), pattern(4'hE, op));
    step(0, 0, 6, 1, 2, pattern(4'h1, 0), pattern(4'h2, 0));
    step(0, 9, 6, 1, 2, pattern(4'h1, 1), pattern(4'h2, 1));
    // mixed stream
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step((r % 5) != 0, $urandom % 16, $urandom % 32, $urandom % 8, $urandom % 8,
           {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
    end
    step(0, 0, 0, 0, 0, '0, '0);
    @(negedge clk_i); check();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule